// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is a synthesizable, clocked model of the device side of an asynchronous parallel NOR flash. It watches the chip-enable, write-enable and output-enable pins together with the address and 16-bit data buses. Each completed write cycle feeds a command decoder. Only unlock-style write sequences with exact address and data values start an internal operation. The address of a write is taken on the falling write-enable edge. The data is taken on the rising edge.

The small on-chip array is split into equal sectors, and a lock pin per sector guards each one. Word program, sector erase and chip erase run on internal cycle counters. While one of them runs, a read returns a status word instead of array data. That status word carries a data-polling bit, a toggle bit and a failure bit. When the operation ends, reads return array contents again. Holding the hardware reset low stops any operation and floats the data bus.

Top module: `nor_flash_ctrl`

## Requirements
- R1: An erased word reads 16'hFFFF. Programming stores old AND new, so a 0 bit only returns to 1 through an erase.
- R2: Word program uses four write cycles: (UNLOCK_A1, 16'hAA), (UNLOCK_A2, 16'h55), (UNLOCK_A1, 16'hA0), then (target, data). After PROG_CYCLES clocks the result is readable.
- R3: While an operation is in progress, every write is ignored, including a complete program sequence.
- R4: Sector erase uses six write cycles: (A1, AA), (A2, 55), (A1, 80), (A1, AA), (A2, 55), then data 16'h0030. The sector is taken from address bits [AW-1:AW-3] as they were at the falling write-enable edge of the sixth cycle. After SE_CYCLES every word of that sector reads 16'hFFFF.
- R5: Chip erase uses the same first five cycles and ends with (A1, 16'h0010). After CE_CYCLES every unlocked sector reads 16'hFFFF, and locked sectors keep their contents.
- R6: A program or sector erase aimed at a sector whose sectorLock bit is 1 ends at once. The next read returns unchanged array data, not status.
- R7: A write that does not match the next expected step returns the decoder to read mode with no effect. A correct sequence that follows it still works.
- R8: While busy, a read returns a status word. Bit 7 is the complement of the programmed data's bit 7, or 0 during an erase. Bit 6 is 0 on the first read after a start and flips after each read. Bit 5 is the failure flag. All other bits are 0.
- R9: A program that tries to turn a 0 into a 1 still stores old AND new. The device then holds the status word with bit 5 set until a write of 16'h00F0 to any address.
- R10: While rstN is low, dataOutEn is 0 and any operation is aborted. A word being programmed at that moment is left reading 16'h0000. After release the device is in read mode.
- R11: dataOutEn is 1 only while ceN and oeN are low, weN is high and rstN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock that samples the bus pins and drives the timers |
| rstN | input | 1 | Active-low hardware reset |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addrIn | input | AW | Word address |
| dataIn | input | DW | Write data |
| sectorLock | input | NS | Lock flag per sector, 1 = protected |
| dataOut | output | DW | Read data or status word |
| dataOutEn | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
On the sixth erase cycle, the bench moves the address between the two write-enable edges. A design that latched the address at the rising edge would erase the wrong sector. It issues a whole program sequence during a busy period, which exposes a decoder that keeps listening while busy. It sends broken unlock sequences and tries to program 0 bits back to 1, which a design without the AND rule or the sticky failure state would report as clean. It checks that locked sectors survive both erase kinds. It also asserts reset in the middle of a program, which catches a model that finishes the write or keeps driving the bus.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef struct packed {
    logic captureAddr;
    logic captureTarget;
    logic progWrite;
    logic progCorrupt;
    logic eraseApply;
    logic showStatus;
    logic pollErase;
    logic toggleBit;
    logic failFlag;
  } ctlStrobe_t;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int FAIL_BIT   = 5;

endpackage

// File: rtl/nfc_datapath.sv
module nfc_datapath
  import nfc_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int NS = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  input  logic [NS-1:0] eraseMask,
  input  ctlStrobe_t    ctl,
  output logic [AW-1:0] addrLatched,
  output logic          progBad,
  output logic [DW-1:0] dataOut
);

  localparam int WORDS = 1 << AW;
  localparam int WPS   = WORDS / NS;

  logic [DW-1:0] memArr [WORDS];
  logic [AW-1:0] addrQ;
  logic [AW-1:0] tgtAddr;
  logic [DW-1:0] tgtData;
  logic [DW-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (ctl.captureAddr) addrQ <= addrIn;
    if (ctl.captureTarget) begin
      tgtAddr <= addrQ;
      tgtData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.eraseApply) begin
      for (int i = 0; i < WORDS; i++) begin
        if (eraseMask[i / WPS]) memArr[i] <= '1;
      end
    end else if (ctl.progCorrupt) begin
      memArr[tgtAddr] <= '0;
    end else if (ctl.progWrite) begin
      memArr[tgtAddr] <= memArr[tgtAddr] & tgtData;
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[POLL_BIT]   = ctl.pollErase ? 1'b0 : ~tgtData[POLL_BIT];
    statusWord[TOGGLE_BIT] = ctl.toggleBit;
    statusWord[FAIL_BIT]   = ctl.failFlag;
  end

  assign addrLatched = addrQ;
  assign progBad     = |(tgtData & ~memArr[tgtAddr]);
  assign dataOut     = ctl.showStatus ? statusWord : memArr[addrIn];

endmodule

// File: rtl/nfc_control.sv
module nfc_control
  import nfc_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int NS = 8,
  parameter int PROG_CYCLES = 40,
  parameter int SE_CYCLES = 60,
  parameter int CE_CYCLES = 90,
  parameter logic [AW-1:0] UNLOCK_A1 = 'h55,
  parameter logic [AW-1:0] UNLOCK_A2 = 'h2A,
  parameter logic [DW-1:0] KEY_1 = 'hAA,
  parameter logic [DW-1:0] KEY_2 = 'h55,
  parameter logic [DW-1:0] CMD_PROG = 'hA0,
  parameter logic [DW-1:0] CMD_ERASE = 'h80,
  parameter logic [DW-1:0] CMD_SECTOR = 'h30,
  parameter logic [DW-1:0] CMD_CHIP = 'h10,
  parameter logic [DW-1:0] CMD_CLEAR = 'hF0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [DW-1:0] dataIn,
  input  logic [AW-1:0] addrLatched,
  input  logic [NS-1:0] sectorLock,
  input  logic          progBad,
  output ctlStrobe_t    ctl,
  output logic [NS-1:0] eraseMask,
  output logic          dataOutEn
);

  localparam int SB    = $clog2(NS);
  localparam int MAXC  = (CE_CYCLES > SE_CYCLES) ?
                         ((CE_CYCLES > PROG_CYCLES) ? CE_CYCLES : PROG_CYCLES) :
                         ((SE_CYCLES > PROG_CYCLES) ? SE_CYCLES : PROG_CYCLES);
  localparam int TW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PADDR, SQ_ERA1, SQ_ERA2, SQ_ERA3
  } seqState_t;

  typedef enum logic [2:0] {
    OP_READ, OP_PROG, OP_SERASE, OP_CERASE, OP_FAIL
  } opState_t;

  seqState_t     seqQ, seqD;
  opState_t      opQ, opD;
  logic [TW-1:0] timerQ, timerD;
  logic [NS-1:0] maskQ, maskD;
  logic          weQ, rdQ, toggleQ, toggleD;
  logic          weFall, weRise, rdActive, rdEnd;
  logic          atA1, atA2, secLocked;
  logic [SB-1:0] wrSector;

  assign weFall    = weQ & ~weN & ~ceN;
  assign weRise    = ~weQ & weN & ~ceN;
  assign rdActive  = ~ceN & ~oeN & weN;
  assign rdEnd     = rdQ & ~rdActive;
  assign atA1      = (addrLatched == UNLOCK_A1);
  assign atA2      = (addrLatched == UNLOCK_A2);
  assign wrSector  = addrLatched[AW-1 -: SB];
  assign secLocked = sectorLock[wrSector];

  always_comb begin
    seqD    = seqQ;
    opD     = opQ;
    timerD  = timerQ;
    maskD   = maskQ;
    toggleD = toggleQ;
    ctl     = '0;

    ctl.captureAddr = weFall;
    ctl.showStatus  = (opQ != OP_READ);
    ctl.pollErase   = (opQ == OP_SERASE) || (opQ == OP_CERASE);
    ctl.failFlag    = (opQ == OP_FAIL);
    ctl.toggleBit   = toggleQ;
    ctl.progCorrupt = ~rstN && (opQ == OP_PROG);

    if (rdEnd && opQ != OP_READ) toggleD = ~toggleQ;

    unique case (opQ)
      OP_READ: begin
        if (weRise) begin
          seqD = SQ_IDLE;
          unique case (seqQ)
            SQ_IDLE: if (atA1 && dataIn == KEY_1) seqD = SQ_KEY1;
            SQ_KEY1: if (atA2 && dataIn == KEY_2) seqD = SQ_KEY2;
            SQ_KEY2: begin
              if (atA1 && dataIn == CMD_PROG)  seqD = SQ_PADDR;
              if (atA1 && dataIn == CMD_ERASE) seqD = SQ_ERA1;
            end
            SQ_PADDR: begin
              if (!secLocked) begin
                ctl.captureTarget = 1'b1;
                opD     = OP_PROG;
                timerD  = TW'(PROG_CYCLES - 1);
                toggleD = 1'b0;
              end
            end
            SQ_ERA1: if (atA1 && dataIn == KEY_1) seqD = SQ_ERA2;
            SQ_ERA2: if (atA2 && dataIn == KEY_2) seqD = SQ_ERA3;
            SQ_ERA3: begin
              if (dataIn == CMD_SECTOR && !secLocked) begin
                opD     = OP_SERASE;
                maskD   = NS'(1) << wrSector;
                timerD  = TW'(SE_CYCLES - 1);
                toggleD = 1'b0;
              end else if (dataIn == CMD_CHIP && atA1) begin
                opD     = OP_CERASE;
                maskD   = ~sectorLock;
                timerD  = TW'(CE_CYCLES - 1);
                toggleD = 1'b0;
              end
            end
            default: seqD = SQ_IDLE;
          endcase
        end
      end
      OP_PROG: begin
        if (timerQ == '0) begin
          ctl.progWrite = 1'b1;
          opD = progBad ? OP_FAIL : OP_READ;
        end else begin
          timerD = timerQ - 1'b1;
        end
      end
      OP_SERASE, OP_CERASE: begin
        if (timerQ == '0) begin
          ctl.eraseApply = 1'b1;
          opD = OP_READ;
        end else begin
          timerD = timerQ - 1'b1;
        end
      end
      OP_FAIL: begin
        if (weRise && dataIn == CMD_CLEAR) opD = OP_READ;
      end
      default: opD = OP_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ    <= SQ_IDLE;
      opQ     <= OP_READ;
      timerQ  <= '0;
      maskQ   <= '0;
      weQ     <= 1'b1;
      rdQ     <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      seqQ    <= seqD;
      opQ     <= opD;
      timerQ  <= timerD;
      maskQ   <= maskD;
      weQ     <= weN;
      rdQ     <= rdActive;
      toggleQ <= toggleD;
    end
  end

  assign eraseMask = maskQ;
  assign dataOutEn = rstN & rdActive;

endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nfc_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int NS = 8,
  parameter int PROG_CYCLES = 40,
  parameter int SE_CYCLES = 60,
  parameter int CE_CYCLES = 90,
  parameter logic [AW-1:0] UNLOCK_A1 = 'h55,
  parameter logic [AW-1:0] UNLOCK_A2 = 'h2A
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  input  logic [NS-1:0] sectorLock,
  output logic [DW-1:0] dataOut,
  output logic          dataOutEn
);

  ctlStrobe_t    ctlBus;
  logic [NS-1:0] eraseMask;
  logic [AW-1:0] addrLatched;
  logic          progBad;

  nfc_control #(
    .AW(AW), .DW(DW), .NS(NS),
    .PROG_CYCLES(PROG_CYCLES), .SE_CYCLES(SE_CYCLES), .CE_CYCLES(CE_CYCLES),
    .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .dataIn(dataIn), .addrLatched(addrLatched), .sectorLock(sectorLock),
    .progBad(progBad), .ctl(ctlBus), .eraseMask(eraseMask),
    .dataOutEn(dataOutEn)
  );

  nfc_datapath #(.AW(AW), .DW(DW), .NS(NS)) dp_i (
    .clk(clk), .addrIn(addrIn), .dataIn(dataIn), .eraseMask(eraseMask),
    .ctl(ctlBus), .addrLatched(addrLatched), .progBad(progBad),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/nfc_checker.sv
module nfc_checker
  import nfc_pkg::*;
#(
  parameter int DW = 16,
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          dataOutEn,
  input logic [DW-1:0] dataOut,
  input ctlStrobe_t    ctlBus,
  input logic [NS-1:0] eraseMask,
  input logic [NS-1:0] sectorLock
);

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlBus.progWrite, ctlBus.eraseApply, ctlBus.captureTarget})); // R2

  AST_PROG_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.progWrite |=> (!ctlBus.showStatus || ctlBus.failFlag)); // R2

  AST_ERASE_TO_READ: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.eraseApply |=> !ctlBus.showStatus); // R4

  AST_LOCKED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.eraseApply |-> ((eraseMask & sectorLock) == '0)); // R5

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutEn && ctlBus.showStatus && ctlBus.pollErase) |-> !dataOut[POLL_BIT]); // R8

  AST_HIZ_IN_RESET: assert property (@(posedge clk)
    !rstN |-> !dataOutEn); // R10

endmodule

bind nor_flash_ctrl nfc_checker #(.DW(DW), .NS(NS)) chk_i (
  .clk(clk), .rstN(rstN), .dataOutEn(dataOutEn), .dataOut(dataOut),
  .ctlBus(ctlBus), .eraseMask(eraseMask), .sectorLock(sectorLock)
);

// File: tb/nor_flash_ctrl_tb_top.sv
`timescale 1ns/1ps
module nor_flash_ctrl_tb_top;

  localparam int AW = 7;
  localparam int DW = 16;
  localparam int NS = 8;
  localparam int WORDS = 1 << AW;
  localparam int PROG_C = 40;
  localparam int SE_C = 60;
  localparam int CE_C = 90;
  localparam logic [AW-1:0] A1 = 7'h55;
  localparam logic [AW-1:0] A2 = 7'h2A;

  logic clk = 1'b0;
  logic rstN, ceN, weN, oeN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic [NS-1:0] sectorLock;
  logic [DW-1:0] dataOut;
  logic dataOutEn;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [WORDS];

  always #2 clk = ~clk;

  nor_flash_ctrl #(.AW(AW), .DW(DW), .NS(NS), .PROG_CYCLES(PROG_C),
    .SE_CYCLES(SE_C), .CE_CYCLES(CE_C), .UNLOCK_A1(A1), .UNLOCK_A2(A2)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .sectorLock(sectorLock),
    .dataOut(dataOut), .dataOutEn(dataOutEn));

  function automatic logic [DW-1:0] statusWord(logic isErase, logic d7, logic tog, logic fail);
    logic [DW-1:0] s = '0;
    s[7] = isErase ? 1'b0 : ~d7;
    s[6] = tog;
    s[5] = fail;
    return s;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ceN = 1'b0; addrIn = a; dataIn = ~d; weN = 1'b0;
    @(negedge clk);
    addrIn = ~a; dataIn = d;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [DW-1:0] v, output logic en);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; addrIn = a;
    @(negedge clk);
    v = dataOut; en = dataOutEn;
    oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic readCheck(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] v;
    logic en;
    busRead(a, v, en);
    check(req, {15'd0, en}, 16'd1);
    check(req, v, exp);
  endtask

  task automatic progSeq(logic [AW-1:0] a, logic [DW-1:0] d);
    busWrite(A1, 16'hAA); busWrite(A2, 16'h55); busWrite(A1, 16'hA0); busWrite(a, d);
  endtask

  task automatic eraseSeq(logic [AW-1:0] a, logic [DW-1:0] cmd);
    busWrite(A1, 16'hAA); busWrite(A2, 16'h55); busWrite(A1, 16'h80);
    busWrite(A1, 16'hAA); busWrite(A2, 16'h55); busWrite(a, cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic en;
    void'($urandom(32'd20240611));
    rstN = 1'b0; ceN = 1'b0; weN = 1'b1; oeN = 1'b0;
    addrIn = '0; dataIn = '0; sectorLock = '0;
    idle(3);
    check("R10 bus floats in reset", {15'd0, dataOutEn}, 16'd0);
    oeN = 1'b1; ceN = 1'b1;
    rstN = 1'b1;
    idle(2);

    // R5/R1: full erase from unknown start
    eraseSeq(A1, 16'h10);
    busRead(7'h03, v, en);
    check("R8 erase poll status", v, statusWord(1'b1, 1'b0, 1'b0, 1'b0));
    idle(CE_C);
    readCheck("R1 erased word", 7'h00, 16'hFFFF);
    readCheck("R1 erased word", 7'h7F, 16'hFFFF);

    // R11: chip not enabled
    @(negedge clk); ceN = 1'b1; oeN = 1'b0;
    @(negedge clk);
    check("R11 no drive without ce", {15'd0, dataOutEn}, 16'd0);
    oeN = 1'b1;

    progSeq(7'h25, 16'h0000); idle(PROG_C + 4);
    readCheck("R2 program sector2", 7'h25, 16'h0000);
    sectorLock = 8'b1000_0100;

    // R6: program into locked sector
    progSeq(7'h26, 16'h1111);
    readCheck("R6 locked program no status", 7'h26, 16'hFFFF);

    // R2/R8: program with status polling
    progSeq(7'h60, 16'h1234);
    busRead(7'h60, v, en);
    check("R8 first poll", v, statusWord(1'b0, 1'b0, 1'b0, 1'b0));
    busRead(7'h60, v, en);
    check("R8 toggled poll", v, statusWord(1'b0, 1'b0, 1'b1, 1'b0));
    idle(PROG_C);
    readCheck("R2 programmed value", 7'h60, 16'h1234);

    // R3: writes ignored while busy
    progSeq(7'h61, 16'h00FF);
    progSeq(7'h62, 16'h0000);
    idle(PROG_C);
    readCheck("R3 busy program result", 7'h61, 16'h00FF);
    readCheck("R3 ignored program", 7'h62, 16'hFFFF);

    // R7: broken sequence, then a correct one
    busWrite(A1, 16'hAA); busWrite(A1, 16'h55); busWrite(A1, 16'hA0); busWrite(7'h63, 16'h0000);
    readCheck("R7 broken sequence no effect", 7'h63, 16'hFFFF);
    progSeq(7'h63, 16'h5555); idle(PROG_C + 4);
    readCheck("R7 decoder recovered", 7'h63, 16'h5555);

    // R9: 0 -> 1 attempt
    progSeq(7'h60, 16'h1235); idle(PROG_C + 4);
    busRead(7'h60, v, en);
    check("R9 fail flag", {15'd0, v[5]}, 16'd1);
    check("R9 fail poll bit", {15'd0, v[7]}, 16'd1);
    busWrite(7'h11, 16'hF0);
    readCheck("R9 after clear AND result", 7'h60, 16'h1234);

    // R4: sector erase, address taken at falling edge (busWrite moves address to ~a)
    progSeq(7'h15, 16'h0F0F); idle(PROG_C + 4);
    progSeq(7'h6F, 16'hA5A5); idle(PROG_C + 4);
    eraseSeq(7'h10, 16'h30);
    busRead(7'h15, v, en);
    check("R8 sector erase status", v, statusWord(1'b1, 1'b0, 1'b0, 1'b0));
    idle(SE_C);
    readCheck("R4 sector erased", 7'h15, 16'hFFFF);
    readCheck("R4 rise-edge address sector kept", 7'h6F, 16'hA5A5);

    // R6: erase of locked sector
    eraseSeq(7'h20, 16'h30);
    readCheck("R6 locked erase immediate", 7'h25, 16'h0000);
    idle(SE_C);
    readCheck("R6 locked erase kept", 7'h25, 16'h0000);

    // R5: chip erase keeps locked sectors
    eraseSeq(A1, 16'h10); idle(CE_C + 4);
    readCheck("R5 locked sector kept", 7'h25, 16'h0000);
    readCheck("R5 unlocked erased", 7'h60, 16'hFFFF);
    readCheck("R5 unlocked erased", 7'h63, 16'hFFFF);

    // random phase on unlocked sectors
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    for (int it = 0; it < 40; it++) begin
      int s;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic isBad;
      s = int'($urandom % NS);
      if (s == 2 || s == 7) s = 0;
      if (it % 7 == 6) begin
        eraseSeq(AW'(s * 16), 16'h30); idle(SE_C + 4);
        for (int w = 0; w < 16; w++) model[s * 16 + w] = 16'hFFFF;
        readCheck("R4 random sector erase", AW'(s * 16 + 5), 16'hFFFF);
      end else begin
        a = AW'(s * 16 + int'($urandom % 16));
        d = DW'($urandom);
        if ($urandom % 4 != 0) d = d & model[a];
        isBad = |(d & ~model[a]);
        progSeq(a, d);
        busRead(a, v, en);
        check("R8 random poll", v, statusWord(1'b0, d[7], 1'b0, 1'b0));
        idle(PROG_C);
        if (isBad) begin
          busRead(a, v, en);
          check("R9 random fail flag", {15'd0, v[5]}, 16'd1);
          busWrite(A1, 16'hF0);
        end
        model[a] = model[a] & d;
        readCheck("R1 random program AND", a, model[a]);
      end
    end

    // R10: reset in the middle of a program
    progSeq(7'h30, 16'h0F00);
    idle(10);
    @(negedge clk); rstN = 1'b0; ceN = 1'b0; oeN = 1'b0; addrIn = 7'h30;
    @(negedge clk);
    check("R10 outputs float", {15'd0, dataOutEn}, 16'd0);
    idle(2);
    oeN = 1'b1; ceN = 1'b1; rstN = 1'b1;
    idle(2);
    readCheck("R10 interrupted word corrupted", 7'h30, 16'h0000);
    readCheck("R10 read mode after reset", 7'h31, model[7'h31]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule